// File: doc/BRIEF.md
# Charge Acquisition Phase Sequencer

This block produces the timing of one readout row for a charge-sensitive amplifier front end. A synchronisation input starts a cycle counter. Every programmed time is an absolute count of clock cycles after that synchronisation event. From the counter the block decodes three consecutive amplifier phases: reset, then offset, then signal. It also places a single-cycle charge-injection strobe inside the offset phase and another inside the signal phase. A filter-acceleration pulse follows each phase start, and a gate for an external line driver closes shortly after the signal phase begins and opens again shortly after the signal phase ends. A one-cycle completion pulse follows the last signal count.

The time values arrive as parallel inputs. A configuration checker tests them against the ordering, spacing and parity rules of the selected ADC power mode. High-power mode needs a spacing of one cycle. Low-power mode needs a spacing of two cycles and allows only even time values. While the configuration is illegal, an error flag is raised and every timing output is held low.

Top module: `phseq_top`

## Requirements
- R1: When sync_i is high at a rising clock edge and the configuration is legal, the count is 0 in the next cycle and then rises by one per cycle. A sync_i during a running sequence restarts the count at 0.
- R2: ph_rst_o, ph_off_o and ph_sig_o are each high for the counts from their start value to their end value, both ends included, and never overlap.
- R3: inj_aux_o and inj_main_o are each high for exactly the one cycle whose count equals inj_aux_at_i or inj_main_at_i.
- R4: filt_acc_o is high for acc_len_i cycles that begin acc_dly_i counts after each of the three phase starts. When windows overlap, the output is their union.
- R5: gate_o is high for counts from gate_on_i through gate_off_i minus 1.
- R6: done_o is high for one cycle, at count sig_end_i plus 1. The sequence ends after count gate_off_i, and all outputs are low while no sequence runs.
- R7: Legality of the ordering uses a spacing m, with m = 1 when adc_hp_i = 1 and m = 2 when adc_hp_i = 0. The rules are: rst_start_i >= m; each start <= its end; off_start_i - rst_end_i >= m; sig_start_i - off_end_i >= m.
- R8: When adc_hp_i = 0, every time input must be even: the six phase bounds, both injection times, both gate times and acc_dly_i. acc_len_i is exempt.
- R9: Placement rules for legality are: inj_aux_at_i lies within the offset phase; inj_main_at_i lies within the signal phase; sig_start_i < gate_on_i <= sig_end_i; gate_off_i > sig_end_i.
- R10: An illegal configuration sets cfg_err_o, forces all timing outputs low, ignores sync_i and aborts a running sequence. After the configuration becomes legal again, outputs stay low until the next sync_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Acquisition clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Row synchronisation, starts or restarts the count |
| adc_hp_i | input | 1 | 1 = ADC high-power mode, 0 = low-power mode |
| rst_start_i | input | CNT_W | First count of reset phase |
| rst_end_i | input | CNT_W | Last count of reset phase |
| off_start_i | input | CNT_W | First count of offset phase |
| off_end_i | input | CNT_W | Last count of offset phase |
| sig_start_i | input | CNT_W | First count of signal phase |
| sig_end_i | input | CNT_W | Last count of signal phase |
| inj_aux_at_i | input | CNT_W | Count of the offset-phase injection strobe |
| inj_main_at_i | input | CNT_W | Count of the signal-phase injection strobe |
| gate_on_i | input | CNT_W | First count with line-driver gate closed |
| gate_off_i | input | CNT_W | Count at which the gate opens again; last count of the sequence |
| acc_dly_i | input | CNT_W | Delay from each phase start to its acceleration pulse |
| acc_len_i | input | CNT_W | Acceleration pulse length in cycles |
| ph_rst_o | output | 1 | Reset phase active |
| ph_off_o | output | 1 | Offset phase active |
| ph_sig_o | output | 1 | Signal phase active |
| inj_aux_o | output | 1 | Offset-phase injection strobe |
| inj_main_o | output | 1 | Signal-phase injection strobe |
| filt_acc_o | output | 1 | Filter-acceleration pulse |
| gate_o | output | 1 | Line-driver gate closed |
| done_o | output | 1 | Row completion pulse |
| cfg_err_o | output | 1 | Configuration illegal |

## Verification
The hardest situations to reach from the ports are the legality boundaries. A gap of exactly m is legal and m minus 1 is not, and a single odd value must be rejected in low-power mode. To reach them, the bench sweeps each time field in turn across a range of values around a legal base configuration in both power modes, and compares the error flag with the rules worked out in the bench. Two sequence-level cases also need deliberate stimulus: a restart in mid-sequence, where sync_i is pulsed at a chosen count, and an abort, where one field is made illegal during a run and then restored. The bench then confirms that the outputs stay low until a new sync_i arrives.

// File: rtl/phseq_pkg.sv
package phseq_pkg;

    localparam int unsigned NUM_PH = 3;

    typedef enum int unsigned {
        PH_RST = 0,
        PH_OFF = 1,
        PH_SIG = 2
    } ph_idx_e;

endpackage

// File: rtl/phseq_window.sv
module phseq_window #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] start_i,
    input  logic [W-1:0] end_i,
    input  logic [W-1:0] acc_dly_i,
    input  logic [W-1:0] acc_len_i,
    output logic         in_ph_o,
    output logic         acc_hit_o
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] rel;
    logic [XW-1:0] lo;
    logic [XW-1:0] hi;
    logic          past_start;

    always_comb begin
        past_start = (cnt_i >= start_i);
        rel        = {1'b0, cnt_i} - {1'b0, start_i};
        lo         = {1'b0, acc_dly_i};
        hi         = lo + {1'b0, acc_len_i};
        in_ph_o    = past_start && (cnt_i <= end_i);
        acc_hit_o  = past_start && (rel >= lo) && (rel < hi);
    end
endmodule

// File: rtl/phseq_cfg_check.sv
module phseq_cfg_check
    import phseq_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic                    hp_i,
    input  logic [NUM_PH-1:0][W-1:0] start_i,
    input  logic [NUM_PH-1:0][W-1:0] end_i,
    input  logic [W-1:0]            inj_aux_i,
    input  logic [W-1:0]            inj_main_i,
    input  logic [W-1:0]            gate_on_i,
    input  logic [W-1:0]            gate_off_i,
    input  logic [W-1:0]            acc_dly_i,
    output logic                    ok_o
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] gap;
    logic          order_ok;
    logic          place_ok;
    logic          odd_any;

    always_comb begin
        gap      = hp_i ? XW'(1) : XW'(2);
        order_ok = ({1'b0, start_i[PH_RST]} >= gap);
        odd_any  = inj_aux_i[0] | inj_main_i[0] | gate_on_i[0]
                 | gate_off_i[0] | acc_dly_i[0];
        for (int i = 0; i < int'(NUM_PH); i++) begin
            order_ok = order_ok && (start_i[i] <= end_i[i]);
            odd_any  = odd_any | start_i[i][0] | end_i[i][0];
            if (i > 0) begin
                order_ok = order_ok &&
                    ({1'b0, start_i[i]} >= ({1'b0, end_i[i-1]} + gap));
            end
        end
        place_ok = (inj_aux_i  >= start_i[PH_OFF]) && (inj_aux_i  <= end_i[PH_OFF])
                && (inj_main_i >= start_i[PH_SIG]) && (inj_main_i <= end_i[PH_SIG])
                && (gate_on_i  >  start_i[PH_SIG]) && (gate_on_i  <= end_i[PH_SIG])
                && (gate_off_i >  end_i[PH_SIG]);
        ok_o = order_ok && place_ok && (hp_i || !odd_any);
    end
endmodule

// File: rtl/phseq_top.sv
module phseq_top
    import phseq_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sync_i,
    input  logic             adc_hp_i,
    input  logic [CNT_W-1:0] rst_start_i,
    input  logic [CNT_W-1:0] rst_end_i,
    input  logic [CNT_W-1:0] off_start_i,
    input  logic [CNT_W-1:0] off_end_i,
    input  logic [CNT_W-1:0] sig_start_i,
    input  logic [CNT_W-1:0] sig_end_i,
    input  logic [CNT_W-1:0] inj_aux_at_i,
    input  logic [CNT_W-1:0] inj_main_at_i,
    input  logic [CNT_W-1:0] gate_on_i,
    input  logic [CNT_W-1:0] gate_off_i,
    input  logic [CNT_W-1:0] acc_dly_i,
    input  logic [CNT_W-1:0] acc_len_i,
    output logic             ph_rst_o,
    output logic             ph_off_o,
    output logic             ph_sig_o,
    output logic             inj_aux_o,
    output logic             inj_main_o,
    output logic             filt_acc_o,
    output logic             gate_o,
    output logic             done_o,
    output logic             cfg_err_o
);
    localparam int unsigned XW = CNT_W + 1;

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t st_d, st_q;

    logic [NUM_PH-1:0][CNT_W-1:0] ph_start;
    logic [NUM_PH-1:0][CNT_W-1:0] ph_end;
    logic [NUM_PH-1:0]            in_ph;
    logic [NUM_PH-1:0]            acc_hit;
    logic                         cfg_ok;
    logic                         act;
    logic                         seq_run;
    logic [CNT_W-1:0]             seq_cnt;

    assign ph_start[PH_RST] = rst_start_i;
    assign ph_start[PH_OFF] = off_start_i;
    assign ph_start[PH_SIG] = sig_start_i;
    assign ph_end[PH_RST]   = rst_end_i;
    assign ph_end[PH_OFF]   = off_end_i;
    assign ph_end[PH_SIG]   = sig_end_i;

    phseq_cfg_check #(.W(CNT_W)) cfg_chk_i (
        .hp_i       (adc_hp_i),
        .start_i    (ph_start),
        .end_i      (ph_end),
        .inj_aux_i  (inj_aux_at_i),
        .inj_main_i (inj_main_at_i),
        .gate_on_i  (gate_on_i),
        .gate_off_i (gate_off_i),
        .acc_dly_i  (acc_dly_i),
        .ok_o       (cfg_ok)
    );

    for (genvar g = 0; g < int'(NUM_PH); g++) begin : g_win
        phseq_window #(.W(CNT_W)) win_i (
            .cnt_i     (st_q.cnt),
            .start_i   (ph_start[g]),
            .end_i     (ph_end[g]),
            .acc_dly_i (acc_dly_i),
            .acc_len_i (acc_len_i),
            .in_ph_o   (in_ph[g]),
            .acc_hit_o (acc_hit[g])
        );
    end

    always_comb begin
        st_d = st_q;
        if (!cfg_ok) begin
            st_d = '0;
        end else if (sync_i) begin
            st_d.run = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.run) begin
            if (st_q.cnt == gate_off_i) begin
                st_d = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seq_run = st_q.run;
    assign seq_cnt = st_q.cnt;

    always_comb begin
        act        = st_q.run && cfg_ok;
        ph_rst_o   = act && in_ph[PH_RST];
        ph_off_o   = act && in_ph[PH_OFF];
        ph_sig_o   = act && in_ph[PH_SIG];
        inj_aux_o  = act && (st_q.cnt == inj_aux_at_i);
        inj_main_o = act && (st_q.cnt == inj_main_at_i);
        filt_acc_o = act && (|acc_hit);
        gate_o     = act && (st_q.cnt >= gate_on_i) && (st_q.cnt < gate_off_i);
        done_o     = act && ({1'b0, st_q.cnt} == ({1'b0, sig_end_i} + XW'(1)));
        cfg_err_o  = !cfg_ok;
    end
endmodule

// File: rtl/phseq_checker.sv
module phseq_checker #(
    parameter int unsigned CNT_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             sync_i,
    input logic             seq_run,
    input logic [CNT_W-1:0] seq_cnt,
    input logic [CNT_W-1:0] gate_off_i,
    input logic             ph_rst_o,
    input logic             ph_off_o,
    input logic             ph_sig_o,
    input logic             inj_aux_o,
    input logic             inj_main_o,
    input logic             filt_acc_o,
    input logic             gate_o,
    input logic             done_o,
    input logic             cfg_err_o
);
    logic [7:0] outs;
    assign outs = {ph_rst_o, ph_off_o, ph_sig_o, inj_aux_o,
                   inj_main_o, filt_acc_o, gate_o, done_o};

    AST_ERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cfg_err_o |-> (outs == '0)); // R10

    AST_PH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ph_rst_o, ph_off_o, ph_sig_o})); // R2

    AST_SYNC_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && !cfg_err_o) |=> (seq_run && seq_cnt == '0)); // R1

    AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_run && !sync_i && !cfg_err_o && seq_cnt != gate_off_i)
        |=> (seq_cnt == CNT_W'($past(seq_cnt) + 1'b1))); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seq_run |-> (outs == '0)); // R6

    AST_DONE_AFTER_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !ph_sig_o); // R6

    AST_AUX_IN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inj_aux_o |-> ph_off_o); // R9

    AST_MAIN_IN_SIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inj_main_o |-> ph_sig_o); // R9
endmodule

bind phseq_top phseq_checker #(.CNT_W(CNT_W)) chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_i     (sync_i),
    .seq_run    (seq_run),
    .seq_cnt    (seq_cnt),
    .gate_off_i (gate_off_i),
    .ph_rst_o   (ph_rst_o),
    .ph_off_o   (ph_off_o),
    .ph_sig_o   (ph_sig_o),
    .inj_aux_o  (inj_aux_o),
    .inj_main_o (inj_main_o),
    .filt_acc_o (filt_acc_o),
    .gate_o     (gate_o),
    .done_o     (done_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/phseq_top_tb_top.sv
`timescale 1ns/1ps
module phseq_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync = 1'b0;
    logic hp = 1'b1;
    int   cfg [12];
    int   nchk = 0;
    int   nerr = 0;
    bit   fin = 1'b0;

    logic [7:0] t [12];
    for (genvar g = 0; g < 12; g++) begin : g_drv
        assign t[g] = cfg[g][7:0];
    end

    logic ph_rst, ph_off, ph_sig, inj_aux, inj_main, facc, gate, done, err;

    always #2.5 clk = ~clk;

    phseq_top #(.CNT_W(8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sync_i(sync), .adc_hp_i(hp),
        .rst_start_i(t[0]), .rst_end_i(t[1]), .off_start_i(t[2]), .off_end_i(t[3]),
        .sig_start_i(t[4]), .sig_end_i(t[5]), .inj_aux_at_i(t[6]), .inj_main_at_i(t[7]),
        .gate_on_i(t[8]), .gate_off_i(t[9]), .acc_dly_i(t[10]), .acc_len_i(t[11]),
        .ph_rst_o(ph_rst), .ph_off_o(ph_off), .ph_sig_o(ph_sig), .inj_aux_o(inj_aux),
        .inj_main_o(inj_main), .filt_acc_o(facc), .gate_o(gate), .done_o(done),
        .cfg_err_o(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic set_base(input int sel);
        int b [12];
        case (sel)
            0: b = '{1, 10, 11, 20, 21, 30, 15, 25, 23, 33, 2, 3};
            1: b = '{2, 10, 12, 20, 22, 30, 14, 26, 24, 34, 2, 3};
            2: b = '{5, 25, 27, 92, 93, 158, 40, 120, 95, 160, 4, 2};
            default: b = '{1, 4, 5, 8, 9, 12, 5, 12, 10, 13, 0, 1};
        endcase
        for (int i = 0; i < 12; i++) cfg[i] = b[i];
    endtask

    function automatic bit legal();
        int m = hp ? 1 : 2;
        bit ok;
        ok = cfg[0] >= m && cfg[0] <= cfg[1] && cfg[2] - cfg[1] >= m
          && cfg[2] <= cfg[3] && cfg[4] - cfg[3] >= m && cfg[4] <= cfg[5]
          && cfg[6] >= cfg[2] && cfg[6] <= cfg[3]
          && cfg[7] >= cfg[4] && cfg[7] <= cfg[5]
          && cfg[8] > cfg[4] && cfg[8] <= cfg[5] && cfg[9] > cfg[5];
        if (!hp) begin
            for (int i = 0; i < 11; i++) if (cfg[i] % 2 != 0) ok = 1'b0;
        end
        return ok;
    endfunction

    function automatic bit acc_exp(input int k);
        bit h = 1'b0;
        for (int p = 0; p < 3; p++) begin
            int s = cfg[2*p];
            if (k >= s && k - s >= cfg[10] && k - s < cfg[10] + cfg[11]) h = 1'b1;
        end
        return h;
    endfunction

    task automatic check_idle(input string tag);
        chk({ph_rst, ph_off, ph_sig, inj_aux, inj_main, facc, gate, done} == 8'h00,
            tag, int'({ph_rst, ph_off, ph_sig, inj_aux, inj_main, facc, gate, done}), 0);
    endtask

    task automatic check_cycle(input int k);
        chk(ph_rst == (k >= cfg[0] && k <= cfg[1]), "R2 reset phase", int'(ph_rst), k);
        chk(ph_off == (k >= cfg[2] && k <= cfg[3]), "R2 offset phase", int'(ph_off), k);
        chk(ph_sig == (k >= cfg[4] && k <= cfg[5]), "R2 signal phase", int'(ph_sig), k);
        chk(inj_aux == (k == cfg[6]), "R3 aux strobe", int'(inj_aux), k);
        chk(inj_main == (k == cfg[7]), "R3 main strobe", int'(inj_main), k);
        chk(facc == acc_exp(k), "R4 filter accel", int'(facc), int'(acc_exp(k)));
        chk(gate == (k >= cfg[8] && k < cfg[9]), "R5 line gate", int'(gate), k);
        chk(done == (k == cfg[5] + 1), "R6 done pulse", int'(done), k);
    endtask

    // R1: one row; optional restart when the count reaches restart_at
    task automatic run_seq(input int restart_at);
        int  k = 0;
        bit  re = 1'b0;
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        forever begin
            check_cycle(k);
            if (!re && k == restart_at) begin
                re = 1'b1;
                sync = 1'b1;
                @(negedge clk);
                sync = 1'b0;
                k = 0;
                chk(ph_rst == (cfg[0] == 0) && done == 1'b0, "R1 restart count zero",
                    int'(ph_rst), 0);
                continue;
            end
            if (k == cfg[9]) break;
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        check_idle("R6 idle after sequence");
        @(negedge clk);
        check_idle("R6 idle stays");
    endtask

    initial begin
        #(200000 * 5);
        if (!fin) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog act=1 exp=0");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        set_base(0);
        hp = 1'b1;
        repeat (3) @(negedge clk);
        check_idle("R6 reset state");
        chk(err == 1'b0, "R7 base legal at reset", int'(err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R6 idle after reset");

        for (int s = 0; s < 4; s++) begin
            set_base(s);
            hp = (s != 1);
            @(negedge clk);
            chk(err == 1'b0, "R7 base legal", int'(err), 0);
            run_seq(-1);
        end
        set_base(0); hp = 1'b1; cfg[10] = 0; cfg[11] = 12;
        @(negedge clk);
        run_seq(-1);
        set_base(2); hp = 1'b1;
        @(negedge clk);
        run_seq(50);
        set_base(1); hp = 1'b0;
        @(negedge clk);
        run_seq(7);

        // R7 R8 R9 legality sweep of one field at a time
        for (int s = 0; s < 2; s++) begin
            for (int f = 0; f < 11; f++) begin
                for (int v = 0; v < 40; v++) begin
                    set_base(s);
                    hp = (s == 0);
                    cfg[f] = v;
                    #1;
                    chk(err == !legal(), "R7 R8 R9 legality", int'(err), int'(!legal()));
                end
            end
        end
        set_base(0); hp = 1'b0;
        #1;
        chk(err == 1'b1, "R8 odd value in low power", int'(err), 1);

        // R10: illegal config ignores sync
        set_base(0); hp = 1'b1; cfg[0] = 0;
        @(negedge clk);
        chk(err == 1'b1, "R10 error flag", int'(err), 1);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        for (int i = 0; i < 5; i++) begin
            check_idle("R10 outputs quiet");
            @(negedge clk);
        end
        // R10: abort mid-run, stay quiet after restore
        set_base(0);
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        repeat (12) @(negedge clk);
        chk(ph_off == 1'b1, "R10 running before abort", int'(ph_off), 1);
        cfg[4] = 20;
        #1;
        chk(err == 1'b1, "R10 abort flag", int'(err), 1);
        check_idle("R10 abort outputs");
        @(negedge clk);
        set_base(0);
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            check_idle("R10 no resume after abort");
        end
        run_seq(-1);

        fin = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule